// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block checks a short sequence of entered values against a secret held in on-chip registers. The default sequence has three values. Each time the entry strobe is raised, the value on the entry bus is compared with the stored value for the current step. A correct value advances the lock one step. A wrong value sends it into a failed state that only reset clears. When the last value matches, the lock opens and stays open until reset.

A single equality comparator serves every step. The step index held in the state register drives the multiplexer select, so the comparator always sees the stored value that belongs to the current position.

The stored values can be rewritten through a small write port, but only while reset is asserted or while the lock is open. In every other state a write request is discarded.

Top module: `combo_lock`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `unlocked` is 0 and the lock waits for the first value of the sequence.
- R2: A strobe whose value equals the stored value for the current step advances to the next step. A match on the last step (index NUM_KEYS-1) makes `unlocked` read 1 from the clock edge that samples that strobe.
- R3: A strobe whose value differs from the stored value for the current step puts the lock into a failed state in which `unlocked` is 0.
- R4: In cycles where `code_stb` is 0, the lock keeps its step and open/failed status whatever is on `code_in`.
- R5: Once open, the lock stays open until reset, and strobes carrying any value leave it open.
- R6: Once failed, the lock stays failed until reset, even if the complete correct sequence is entered afterwards.
- R7: When `key_wr_en` is 1 during reset or while open, `key_wr_data` replaces stored value number `key_wr_idx` (0 is the first step) at that clock edge. An index of NUM_KEYS or above changes nothing.
- R8: A write request made while the lock is neither open nor in reset leaves every stored value unchanged.
- R9: A strobe and a write in the same cycle while open: the write is stored and the lock stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronously forces the first step |
| code_in | input | VAL_W | Entered value |
| code_stb | input | 1 | Marks a freshly presented entry value for one cycle |
| key_wr_en | input | 1 | Request to overwrite one stored value |
| key_wr_idx | input | IDX_W | Which stored value to overwrite |
| key_wr_data | input | VAL_W | New stored value |
| unlocked | output | 1 | 1 while open, 0 while closed |

## Verification
The interesting overlap is an entry strobe and a write to the stored values in the same clock cycle. While the lock is open, both are driven together, with a wrong entry value. The bench requires the lock to stay open. After a reset, it requires that only the newly written value unlocks that step.

The same write is also attempted mid-sequence, where it must be dropped. There the bench judges the result by opening the lock with the old values. The full sweep replaces the value at each step with every possible 4-bit value and expects an open lock only for the single matching one.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        MODE_STEP = 2'd0,
        MODE_OPEN = 2'd1,
        MODE_FAIL = 2'd2
    } lock_mode_e;

endpackage

// File: rtl/lock_key_store.sv
module lock_key_store #(
    parameter int NUM_KEYS = 3,
    parameter int VAL_W    = 4,
    parameter int IDX_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              open_i,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [VAL_W-1:0]                  wr_data_i,
    output logic [NUM_KEYS-1:0][VAL_W-1:0]    keys_o
);

    typedef struct packed {
        logic [NUM_KEYS-1:0][VAL_W-1:0] keys;
    } store_t;

    store_t store_d, store_q;
    logic   wr_allow;

    assign wr_allow = !rst_n || open_i;

    always_comb begin
        store_d = store_q;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (wr_allow && wr_en_i && (wr_idx_i == IDX_W'(k))) begin
                store_d.keys[k] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign keys_o = store_q.keys;

    // R8
    key_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(keys_o));

    // R7
    key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && wr_en_i && wr_idx_i == '0) |=> keys_o[0] == $past(wr_data_i));

endmodule

// File: rtl/lock_key_mux.sv
module lock_key_mux #(
    parameter int NUM_KEYS = 3,
    parameter int VAL_W    = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_KEYS-1:0][VAL_W-1:0] keys_i,
    input  logic [IDX_W-1:0]               sel_i,
    input  logic [VAL_W-1:0]               code_i,
    output logic                           match_o
);

    logic [VAL_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (sel_i == IDX_W'(k)) begin
                picked = keys_i[k];
            end
        end
    end

    assign match_o = (picked == code_i);

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import lock_pkg::*;
#(
    parameter int NUM_KEYS = 3,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             match_i,
    output logic [IDX_W-1:0] sel_o,
    output logic             open_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_KEYS - 1);

    typedef struct packed {
        lock_mode_e       mode;
        logic [IDX_W-1:0] idx;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (fsm_q.mode == MODE_STEP && stb_i) begin
            if (!match_i) begin
                fsm_d.mode = MODE_FAIL;
                fsm_d.idx  = '0;
            end else if (fsm_q.idx == LAST_IDX) begin
                fsm_d.mode = MODE_OPEN;
                fsm_d.idx  = '0;
            end else begin
                fsm_d.idx  = fsm_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{mode: MODE_STEP, idx: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sel_o  = fsm_q.idx;
    assign open_o = (fsm_q.mode == MODE_OPEN);

    // R2
    last_match_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_STEP && stb_i && match_i && sel_o == LAST_IDX) |=> open_o);

    // R3
    mismatch_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_STEP && stb_i && !match_i) |=> (fsm_q.mode == MODE_FAIL && !open_o));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(fsm_q));

    // R5
    open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> open_o);

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mode == MODE_FAIL) |=> (fsm_q.mode == MODE_FAIL));

endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
    parameter  int NUM_KEYS = 3,
    parameter  int VAL_W    = 4,
    localparam int IDX_W    = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] code_in,
    input  logic             code_stb,
    input  logic             key_wr_en,
    input  logic [IDX_W-1:0] key_wr_idx,
    input  logic [VAL_W-1:0] key_wr_data,
    output logic             unlocked
);

    logic [NUM_KEYS-1:0][VAL_W-1:0] keys;
    logic [IDX_W-1:0]               step_sel;
    logic                           step_match;
    logic                           is_open;

    lock_key_store #(.NUM_KEYS(NUM_KEYS), .VAL_W(VAL_W), .IDX_W(IDX_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (is_open),
        .wr_en_i   (key_wr_en),
        .wr_idx_i  (key_wr_idx),
        .wr_data_i (key_wr_data),
        .keys_o    (keys)
    );

    lock_key_mux #(.NUM_KEYS(NUM_KEYS), .VAL_W(VAL_W), .IDX_W(IDX_W)) mux_i (
        .keys_i  (keys),
        .sel_i   (step_sel),
        .code_i  (code_in),
        .match_o (step_match)
    );

    lock_seq_fsm #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (code_stb),
        .match_i (step_match),
        .sel_o   (step_sel),
        .open_o  (is_open)
    );

    assign unlocked = is_open;

    // R1
    reset_closed_chk: assert property (@(posedge clk)
        !rst_n |=> !unlocked);

endmodule

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NK = 3;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] code_in = '0;
    logic          code_stb = 1'b0;
    logic          key_wr_en = 1'b0;
    logic [1:0]    key_wr_idx = '0;
    logic [VW-1:0] key_wr_data = '0;
    logic          unlocked;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [VW-1:0] kmod [NK];

    always #(CLK_PERIOD/2) clk = ~clk;

    combo_lock #(.NUM_KEYS(NK), .VAL_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_stb(code_stb),
        .key_wr_en(key_wr_en), .key_wr_idx(key_wr_idx), .key_wr_data(key_wr_data),
        .unlocked(unlocked)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: unlocked=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic reset_with_keys(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                   input logic [VW-1:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        key_wr_en = 1'b1;
        key_wr_idx = 2'd0; key_wr_data = a;
        @(negedge clk);
        key_wr_idx = 2'd1; key_wr_data = b;
        @(negedge clk);
        key_wr_idx = 2'd2; key_wr_data = c;
        @(negedge clk);
        key_wr_en = 1'b0;
        rst_n = 1'b1;
        kmod[0] = a; kmod[1] = b; kmod[2] = c;
    endtask

    task automatic plain_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input logic [VW-1:0] v);
        @(negedge clk);
        code_in = v;
        code_stb = 1'b1;
        @(negedge clk);
        code_stb = 1'b0;
    endtask

    task automatic write_key(input logic [1:0] idx, input logic [VW-1:0] v);
        @(negedge clk);
        key_wr_en = 1'b1; key_wr_idx = idx; key_wr_data = v;
        @(negedge clk);
        key_wr_en = 1'b0;
    endtask

    task automatic enter_model();
        for (int s = 0; s < NK; s++) strobe(kmod[s]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: unlocked=%b expected=finished run", unlocked);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 and R7: load stored values during reset
        reset_with_keys(4'h9, 4'h3, 4'hC);
        check("R1 closed after reset", unlocked, 1'b0);

        // R2 / R3 sweep: replace the value at step p by every value v
        for (int p = 0; p < NK; p++) begin
            for (int v = 0; v < (1 << VW); v++) begin
                plain_reset();
                check("R1 closed after reset", unlocked, 1'b0);
                for (int s = 0; s < NK; s++) begin
                    strobe((s == p) ? VW'(v) : kmod[s]);
                    if (s < NK - 1) check("R2 closed mid-sequence", unlocked, 1'b0);
                end
                if (VW'(v) == kmod[p]) check("R2 full match opens", unlocked, 1'b1);
                else                   check("R3 mismatch stays closed", unlocked, 1'b0);
            end
        end

        // R6: failed state ignores a later correct sequence
        plain_reset();
        strobe(kmod[0]);
        strobe(kmod[1] ^ 4'h1);
        enter_model();
        check("R6 failed holds", unlocked, 1'b0);

        // R4: bus activity without strobe changes nothing
        plain_reset();
        strobe(kmod[0]);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            code_in = VW'(i * 5);
        end
        strobe(kmod[1]);
        @(negedge clk); code_in = 4'h0;
        @(negedge clk); code_in = 4'hF;
        check("R4 idle keeps closed", unlocked, 1'b0);
        strobe(kmod[2]);
        check("R4 step kept across idle", unlocked, 1'b1);

        // R5: strobes while open change nothing
        for (int i = 0; i < 4; i++) strobe(VW'(i + 1));
        check("R5 open holds", unlocked, 1'b1);

        // R7: out-of-range index ignored while open
        write_key(2'd3, 4'h0);
        plain_reset();
        enter_model();
        check("R7 index 3 ignored", unlocked, 1'b1);

        // R7: write while open replaces step 2 value
        write_key(2'd2, 4'h6);
        plain_reset();
        enter_model();
        check("R7 old value rejected", unlocked, 1'b0);
        kmod[2] = 4'h6;
        plain_reset();
        enter_model();
        check("R7 new value accepted", unlocked, 1'b1);

        // R8: write mid-sequence dropped
        plain_reset();
        strobe(kmod[0]);
        write_key(2'd0, 4'h1);
        write_key(2'd1, 4'h1);
        strobe(kmod[1]);
        strobe(kmod[2]);
        check("R8 write dropped mid-sequence", unlocked, 1'b1);
        plain_reset();
        enter_model();
        check("R8 stored values intact", unlocked, 1'b1);

        // R9: strobe and write in same cycle while open
        @(negedge clk);
        code_in = 4'hE; code_stb = 1'b1;
        key_wr_en = 1'b1; key_wr_idx = 2'd1; key_wr_data = 4'h5;
        @(negedge clk);
        code_stb = 1'b0; key_wr_en = 1'b0;
        check("R9 stays open", unlocked, 1'b1);
        plain_reset();
        enter_model();
        check("R9 old value rejected", unlocked, 1'b0);
        kmod[1] = 4'h5;
        plain_reset();
        enter_model();
        check("R9 written value accepted", unlocked, 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule